// File: doc/BRIEF.md
# Stop Mode Power Sequencer

This block chooses the low-power level a small microcontroller drops into when its CPU accepts a stop instruction, and brings the part back out again. Two stop depths exist. In the shallow level every register stays powered and any wake source returns the part to run. In the deep level the I/O control signals are frozen, the core except RAM is powered off, and the regulator drops to standby. A debug-enable bit overrides the deep request: the block falls back to the shallow level and keeps regulation and the debug clocks at full strength. While stopped with debug enabled, a debug wake command moves the block into a halted debug state.

Leaving the deep level is a full restart. The block raises a power-on-style reset for a fixed number of cycles. It also sets a sticky partial-power-down flag and keeps the pin freeze in place, so that boot code can take a recovery path. Both are released only when software writes a one to the acknowledge bit. The stop-level select, the debug enable, the RTC wake enable and the two analog options are captured when the stop instruction is accepted. Writes to them after that point do not affect the current stop.

Top module: `pwr_stop_seq`

## Requirements
- R1: After `por_n` is released, `mode` is 0 (run). `ppd_flag`, `pin_latch_en`, `core_off_req`, `reg_standby_req`, `por_rst`, `lvd_force_on`, `irq_pullup_off` and `mem_req_err` are 0, and `dbg_clk_en` is 1.
- R2: A `stop_req` seen in run moves `mode` one clock later to 2 (deep stop) when `sel_stop2`=1 and `dbg_en`=0. It moves `mode` to 1 (shallow stop) when `sel_stop2`=0, or when `dbg_en`=1.
- R3: In either stop level, `reg_standby_req` is 1 and `dbg_clk_en` is 0 if debug was disabled at entry. If debug was enabled at entry, `reg_standby_req` is 0 and `dbg_clk_en` is 1.
- R4: In deep stop, `pin_latch_en`, `core_off_req`, `irq_pullup_off` and `reg_standby_req` are all 1.
- R5: Deep stop is left on `rst_pin_n`=0, on `irq_n`=0, or on `rtc_irq`=1 when the RTC wake enable was 1 at entry. An `rtc_irq` without that enable leaves the block in deep stop.
- R6: One clock after a deep-stop wake, `mode` is 4 and `por_rst` is 1. Both hold for RST_HOLD clocks (default 4), after which `mode` returns to 0.
- R7: `ppd_flag` reads 1 in the same cycle as the deep-stop wake. It stays 1 after the restart, and `pin_latch_en` stays 1 with it.
- R8: `ack_wr`=1 with `ack_data`=1 clears `ppd_flag` and `pin_latch_en` one clock later. `ack_wr`=1 with `ack_data`=0 changes nothing.
- R9: In shallow stop, a wake source (pin reset, IRQ, or enabled RTC) returns `mode` to 0 one clock later. `por_rst` stays 0 and `ppd_flag` is unchanged.
- R10: In shallow stop with debug enabled at entry, `dbg_wake_cmd` sets `mode` to 3 one clock later, and `dbg_resume` then returns it to 0. Without debug enabled at entry, `dbg_wake_cmd` is ignored.
- R11: `mem_req_err` follows `mem_status_req` in the same cycle while `mode` is 1 or 2, and is 0 in every other mode.
- R12: `lvd_force_on` is 1 in shallow stop when `cmp_bg_opt` or `xosc_range_opt` was 1 at entry.
- R13: Changes to `sel_stop2`, `dbg_en`, `rtc_wake_en`, `cmp_bg_opt` and `xosc_range_opt` while stopped do not affect the current stop.
- R14: A wake source present in the same cycle as an accepted `stop_req` is kept. The block enters the chosen stop and leaves it one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | CPU accepted a stop instruction (one-cycle pulse) |
| sel_stop2 | input | 1 | Stop-level select, 1 asks for deep stop |
| dbg_en | input | 1 | Debug-enable bit |
| rtc_wake_en | input | 1 | RTC interrupt may wake from stop |
| cmp_bg_opt | input | 1 | Comparator bandgap option in use |
| xosc_range_opt | input | 1 | External oscillator range option in use |
| rst_pin_n | input | 1 | Reset pin level, synchronised, active low |
| irq_n | input | 1 | IRQ pin level, active-low wake |
| rtc_irq | input | 1 | RTC interrupt |
| dbg_wake_cmd | input | 1 | Debug link wake command |
| dbg_resume | input | 1 | Debug link resume to run |
| mem_status_req | input | 1 | Debug memory access with status requested |
| ack_wr | input | 1 | Write strobe for the acknowledge bit |
| ack_data | input | 1 | Value written to the acknowledge bit |
| mode | output | 3 | 0 run, 1 shallow stop, 2 deep stop, 3 debug halt, 4 wake reset |
| por_rst | output | 1 | Power-on-style reset to the core |
| pin_latch_en | output | 1 | Freeze I/O control signals |
| core_off_req | output | 1 | Power off core except RAM |
| reg_standby_req | output | 1 | Regulator standby request |
| dbg_clk_en | output | 1 | Keep debug clocks running |
| irq_pullup_off | output | 1 | Force IRQ pull-up off |
| lvd_force_on | output | 1 | Keep low-voltage detect enabled |
| mem_req_err | output | 1 | Debug memory request answered with error |
| ppd_flag | output | 1 | Partial-power-down status flag |

## Verification
The assertions assume that every input is synchronous to `clk` and that `stop_req` is a single-cycle pulse. They also assume that the RTC and debug wake inputs are levels that software and the debug link hold steady until the block has moved. The stimulus applies every input change shortly after a rising edge and returns each pulse to idle before the next action. Wake pins are released only after the mode change has been observed. Configuration inputs are toggled during stop only to show that they are ignored, never in the cycle a stop is accepted unless that cycle is the point of the test.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    M_RUN   = 3'd0,
    M_STOP3 = 3'd1,
    M_STOP2 = 3'd2,
    M_BGND  = 3'd3,
    M_WAKE  = 3'd4
  } pss_mode_e;

  typedef struct packed {
    logic dbg;
    logic rtc_en;
    logic lvd_hold;
  } pss_cfg_t;

  // Debug enable forces the shallow level.
  function automatic pss_mode_e f_stop_level(input logic sel2, input logic dbg);
    return (sel2 && !dbg) ? M_STOP2 : M_STOP3;
  endfunction

  function automatic logic f_wake_hit(input logic irq_n, input logic rtc,
                                      input logic rtc_en, input logic rst_n);
    return !irq_n || (rtc && rtc_en) || !rst_n;
  endfunction
endpackage

// File: rtl/pss_entry.sv
module pss_entry
  import pss_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      accept,
  input  logic      sel_stop2,
  input  logic      dbg_en,
  input  logic      rtc_wake_en,
  input  logic      cmp_bg_opt,
  input  logic      xosc_range_opt,
  output pss_mode_e target,
  output pss_cfg_t  cfg_q
);
  assign target = f_stop_level(sel_stop2, dbg_en);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q.dbg      <= dbg_en;
      cfg_q.rtc_en   <= rtc_wake_en;
      cfg_q.lvd_hold <= cmp_bg_opt || xosc_range_opt;
    end
  end

  assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!por_n)
    !accept |=> $stable(cfg_q));
endmodule

// File: rtl/pss_wake.sv
module pss_wake
  import pss_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic accept,
  input  logic in_stop,
  input  logic irq_n,
  input  logic rtc_irq,
  input  logic rtc_wake_en,
  input  logic cfg_rtc_en,
  input  logic rst_pin_n,
  output logic wake
);
  logic hit_entry, hit_stop, pend_q;

  assign hit_entry = f_wake_hit(irq_n, rtc_irq, rtc_wake_en, rst_pin_n);
  assign hit_stop  = f_wake_hit(irq_n, rtc_irq, cfg_rtc_en, rst_pin_n);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        pend_q <= 1'b0;
    else if (accept)   pend_q <= hit_entry;
    else if (!in_stop) pend_q <= 1'b0;
  end

  assign wake = in_stop && (hit_stop || pend_q);

  assert_pend_kept_R14: assert property (@(posedge clk) disable iff (!por_n)
    accept && hit_entry |=> wake);
endmodule

// File: rtl/pss_flag.sv
module pss_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic ack_wr,
  input  logic ack_data,
  output logic flag_q,
  output logic flag_vis
);
  logic clr;
  assign clr = ack_wr && ack_data;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  assign flag_vis = flag_q || set_i;

  assert_ack_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    flag_q && !clr |=> flag_q);
  assert_ack_one_R8: assert property (@(posedge clk) disable iff (!por_n)
    clr && !set_i |=> !flag_q);
endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
  import pss_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       stop_req,
  input  logic       sel_stop2,
  input  logic       dbg_en,
  input  logic       rtc_wake_en,
  input  logic       cmp_bg_opt,
  input  logic       xosc_range_opt,
  input  logic       rst_pin_n,
  input  logic       irq_n,
  input  logic       rtc_irq,
  input  logic       dbg_wake_cmd,
  input  logic       dbg_resume,
  input  logic       mem_status_req,
  input  logic       ack_wr,
  input  logic       ack_data,
  output logic [2:0] mode,
  output logic       por_rst,
  output logic       pin_latch_en,
  output logic       core_off_req,
  output logic       reg_standby_req,
  output logic       dbg_clk_en,
  output logic       irq_pullup_off,
  output logic       lvd_force_on,
  output logic       mem_req_err,
  output logic       ppd_flag
);
  localparam int CNT_W = $clog2(RST_HOLD) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_HOLD - 1);

  pss_mode_e state_q, state_d, target;
  pss_cfg_t  cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic accept, in_stop, wake, ppd_set, flag_q;

  assign accept  = stop_req && (state_q == M_RUN);
  assign in_stop = (state_q == M_STOP3) || (state_q == M_STOP2);
  assign ppd_set = (state_q == M_STOP2) && wake;

  pss_entry u_entry (
    .clk(clk), .por_n(por_n), .accept(accept), .sel_stop2(sel_stop2),
    .dbg_en(dbg_en), .rtc_wake_en(rtc_wake_en), .cmp_bg_opt(cmp_bg_opt),
    .xosc_range_opt(xosc_range_opt), .target(target), .cfg_q(cfg_q)
  );

  pss_wake u_wake (
    .clk(clk), .por_n(por_n), .accept(accept), .in_stop(in_stop),
    .irq_n(irq_n), .rtc_irq(rtc_irq), .rtc_wake_en(rtc_wake_en),
    .cfg_rtc_en(cfg_q.rtc_en), .rst_pin_n(rst_pin_n), .wake(wake)
  );

  pss_flag u_flag (
    .clk(clk), .por_n(por_n), .set_i(ppd_set), .ack_wr(ack_wr),
    .ack_data(ack_data), .flag_q(flag_q), .flag_vis(ppd_flag)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_RUN:   if (accept) state_d = target;
      M_STOP3: if (wake) state_d = M_RUN;
               else if (dbg_wake_cmd && cfg_q.dbg) state_d = M_BGND;
      M_STOP2: if (wake) state_d = M_WAKE;
      M_BGND:  if (dbg_resume) state_d = M_RUN;
      M_WAKE:  if (cnt_q == CNT_LAST) state_d = M_RUN;
      default: state_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= M_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == M_WAKE) ? cnt_q + 1'b1 : '0;
    end
  end

  assign mode            = state_q;
  assign por_rst         = (state_q == M_WAKE);
  assign pin_latch_en    = (state_q == M_STOP2) || flag_q;
  assign core_off_req    = (state_q == M_STOP2);
  assign irq_pullup_off  = (state_q == M_STOP2);
  assign reg_standby_req = in_stop && !cfg_q.dbg;
  assign dbg_clk_en      = !in_stop || cfg_q.dbg;
  assign lvd_force_on    = (state_q == M_STOP3) && cfg_q.lvd_hold;
  assign mem_req_err     = in_stop && mem_status_req;

  assert_demote_R2: assert property (@(posedge clk) disable iff (!por_n)
    accept && dbg_en |=> mode == 3'd1);
  assert_stop2_pins_R4: assert property (@(posedge clk) disable iff (!por_n)
    mode == 3'd2 |-> pin_latch_en && core_off_req && irq_pullup_off && reg_standby_req);
  assert_full_reg_R3: assert property (@(posedge clk) disable iff (!por_n)
    in_stop && cfg_q.dbg |-> !reg_standby_req && dbg_clk_en);
  assert_reset_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_rst) |-> ppd_flag && pin_latch_en);
  assert_stop3_exit_R9: assert property (@(posedge clk) disable iff (!por_n)
    state_q == M_STOP3 && wake |=> mode == 3'd0 && !por_rst);
  assert_mem_err_R11: assert property (@(posedge clk) disable iff (!por_n)
    !in_stop |-> !mem_req_err);
endmodule

// File: tb/pwr_stop_seq_bench.sv
`timescale 1ns/1ps
module pwr_stop_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n, stop_req, sel_stop2, dbg_en, rtc_wake_en, cmp_bg_opt, xosc_range_opt;
  logic rst_pin_n, irq_n, rtc_irq, dbg_wake_cmd, dbg_resume, mem_status_req, ack_wr, ack_data;
  logic [2:0] mode;
  logic por_rst, pin_latch_en, core_off_req, reg_standby_req, dbg_clk_en;
  logic irq_pullup_off, lvd_force_on, mem_req_err, ppd_flag;

  pwr_stop_seq u_pwr_stop_seq (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {sel_stop2, dbg_en, expected mode[2:0], expected standby}
  localparam logic [5:0] VEC [4] = '{
    6'b0_0_001_1, 6'b0_1_001_0, 6'b1_0_010_1, 6'b1_1_001_0 };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic enter(input logic sel, input logic dbg);
    sel_stop2 = sel; dbg_en = dbg; stop_req = 1'b1;
    step();
    stop_req = 1'b0;
  endtask

  task automatic finish_restart_and_ack();
    repeat (4) step();
    ack_wr = 1'b1; ack_data = 1'b1; step(); ack_wr = 1'b0; ack_data = 1'b0;
  endtask

  initial begin
    por_n = 0; stop_req = 0; sel_stop2 = 0; dbg_en = 0; rtc_wake_en = 0;
    cmp_bg_opt = 0; xosc_range_opt = 0; rst_pin_n = 1; irq_n = 1; rtc_irq = 0;
    dbg_wake_cmd = 0; dbg_resume = 0; mem_status_req = 0; ack_wr = 0; ack_data = 0;
    repeat (3) step();
    por_n = 1; step();
    // R1 reset state
    chk("R1 mode", mode, 0);           chk("R1 ppd_flag", ppd_flag, 0);
    chk("R1 pin_latch_en", pin_latch_en, 0); chk("R1 core_off", core_off_req, 0);
    chk("R1 standby", reg_standby_req, 0);  chk("R1 por_rst", por_rst, 0);
    chk("R1 dbg_clk_en", dbg_clk_en, 1);    chk("R1 lvd", lvd_force_on, 0);

    // Table: stop level choice (R2, R3, R4), then wake by IRQ
    for (int i = 0; i < 4; i++) begin
      enter(VEC[i][5], VEC[i][4]);
      chk("R2 level", mode, int'(VEC[i][3:1]));
      chk("R3 standby", reg_standby_req, int'(VEC[i][0]));
      chk("R3 dbg_clk_en", dbg_clk_en, int'(VEC[i][4]));
      chk("R4 core_off", core_off_req, int'(VEC[i][3:1] == 3'd2));
      irq_n = 1'b0; step(); irq_n = 1'b1;
      if (VEC[i][3:1] == 3'd2) finish_restart_and_ack();
      chk("R2 back in run", mode, 0);
    end
    dbg_en = 0; sel_stop2 = 0;

    // R4, R5, R6, R7, R8, R13: deep stop, RTC wake
    rtc_wake_en = 1; enter(1, 0); rtc_wake_en = 0;
    chk("R4 latch", pin_latch_en, 1); chk("R4 pullup_off", irq_pullup_off, 1);
    chk("R4 standby", reg_standby_req, 1); chk("R4 mode", mode, 2);
    chk("R7 flag before wake", ppd_flag, 0);
    rtc_irq = 1; #1;
    chk("R7 flag same cycle", ppd_flag, 1);
    step(); rtc_irq = 0;
    chk("R6 mode wake", mode, 4); chk("R6 por_rst", por_rst, 1);
    step(); step(); step();
    chk("R6 still holding", por_rst, 1);
    step();
    chk("R6 run after hold", mode, 0); chk("R6 por_rst off", por_rst, 0);
    chk("R7 flag sticky", ppd_flag, 1); chk("R7 latch sticky", pin_latch_en, 1);
    ack_wr = 1; ack_data = 0; step(); ack_wr = 0;
    chk("R8 ack zero flag", ppd_flag, 1); chk("R8 ack zero latch", pin_latch_en, 1);
    ack_wr = 1; ack_data = 1; step(); ack_wr = 0; ack_data = 0;
    chk("R8 ack one flag", ppd_flag, 0); chk("R8 ack one latch", pin_latch_en, 0);

    // R5, R13: RTC ignored without enable at entry; reset pin wakes
    enter(1, 0); rtc_wake_en = 1; sel_stop2 = 0; rtc_irq = 1;
    step(); step();
    chk("R5 rtc ignored", mode, 2); chk("R13 late rtc enable", ppd_flag, 0);
    rtc_irq = 0; rtc_wake_en = 0; rst_pin_n = 0; step(); rst_pin_n = 1;
    chk("R5 reset pin wake", mode, 4);
    finish_restart_and_ack();
    chk("R5 recovered", mode, 0);

    // R9: shallow stop, RTC wake with enable
    rtc_wake_en = 1; enter(0, 0); rtc_wake_en = 0;
    rtc_irq = 1; step(); rtc_irq = 0;
    chk("R9 run", mode, 0); chk("R9 no por_rst", por_rst, 0); chk("R9 flag", ppd_flag, 0);
    enter(0, 0); rst_pin_n = 0; step(); rst_pin_n = 1;
    chk("R9 reset pin in shallow", mode, 0);

    // R14: wake coincident with entry
    irq_n = 0; enter(0, 0); irq_n = 1;
    chk("R14 entered", mode, 1);
    step();
    chk("R14 left", mode, 0);

    // R10, R11: debug wake and memory error
    enter(0, 1); dbg_en = 0;
    mem_status_req = 1; #1;
    chk("R11 err in stop", mem_req_err, 1);
    mem_status_req = 0;
    dbg_wake_cmd = 1; step(); dbg_wake_cmd = 0;
    chk("R10 halt", mode, 3);
    mem_status_req = 1; #1;
    chk("R11 no err in halt", mem_req_err, 0);
    mem_status_req = 0;
    dbg_resume = 1; step(); dbg_resume = 0;
    chk("R10 resume", mode, 0);
    mem_status_req = 1; #1;
    chk("R11 no err in run", mem_req_err, 0);
    mem_status_req = 0;
    enter(0, 0); dbg_en = 1; dbg_wake_cmd = 1; step(); dbg_wake_cmd = 0;
    chk("R10 cmd ignored", mode, 1); chk("R13 late dbg_en", reg_standby_req, 1);
    dbg_en = 0; irq_n = 0; step(); irq_n = 1;

    // R12: LVD hold
    cmp_bg_opt = 1; enter(0, 0); cmp_bg_opt = 0;
    chk("R12 lvd cmp", lvd_force_on, 1);
    step();
    chk("R13 lvd kept", lvd_force_on, 1);
    irq_n = 0; step(); irq_n = 1;
    chk("R12 lvd off in run", lvd_force_on, 0);
    xosc_range_opt = 1; enter(0, 0); xosc_range_opt = 0;
    chk("R12 lvd xosc", lvd_force_on, 1);
    irq_n = 0; step(); irq_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1-chain actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule